// File: doc/BRIEF.md
# Per-Pixel Display Mode Output Stage

This block sits at the end of a scan-out path that delivers one 26-bit pixel word per valid cycle. Each word carries 24 colour bits and a 2-bit mode field stored next to them. The stage reads the mode field of every pixel and turns the colour bits into a final 24-bit RGB value in one of three ways:

- It can treat the low byte as an index into a colour palette.
- It can send each of the three colour bytes through its own channel of that palette.
- It can forward the colour bits unchanged.

Because the choice is made pixel by pixel, palette-based and direct-colour regions can share one screen.

The palette is an internal table of 256 entries. Each entry holds three 8-bit channels. The table is loaded through a one-cycle write port. Every pixel takes the same two-cycle path, so the output stream keeps the shape of the input stream, delayed by exactly two clocks.

Top module: `pxmode_out`

## Requirements
- R1: A pixel word is split into mode = bits 25:24 and colour = bits 23:0. Within the colour, red is bits 23:16, green is bits 15:8 and blue is bits 7:0. The mode bits never appear on `rgb`.
- R2: Mode 00 (indexed): `rgb` equals the whole 24-bit palette entry selected by colour bits 7:0.
- R3: Mode 11 (direct): `rgb` equals colour bits 23:0 unchanged.
- R4: Mode 10 behaves exactly like mode 11.
- R5: Mode 01 (per-channel mapped): output red is the red channel of the entry indexed by input red. Output green is the green channel of the entry indexed by input green. Output blue is the blue channel of the entry indexed by input blue.
- R6: `rgb_vld` is `pix_vld` delayed by exactly two cycles, and the matching `rgb` appears in that same cycle. While no result is being delivered, `rgb` holds its last value.
- R7: When `pal_we` is high, the entry `pal_addr` takes `pal_data` (red 23:16, green 15:8, blue 7:0). A pixel presented in the same cycle as the write, or in any later cycle, sees the new entry.
- R8: A write presented one cycle after a pixel is not seen by that pixel, which gets the old entry.
- R9: After reset every palette entry is zero, and `rgb_vld` and `rgb` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel valid |
| pix_word | input | 26 | Mode field (25:24) and colour (23:0) |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette entry to write |
| pal_data | input | 24 | Palette entry data, red/green/blue |
| rgb_vld | output | 1 | Output pixel valid |
| rgb | output | 24 | Final colour, red/green/blue |

## Verification
The bench builds the block with its default parameters: 8-bit channels and three channels. This gives a 256-entry palette, which the bench fills completely with distinct per-channel patterns.

With every entry distinct, a lookup that uses the wrong index byte or the wrong channel produces a visibly wrong colour. At this size the bench can also reach both ends of the index range. Writes placed in the same cycle as a pixel, and one cycle after it, exercise the exact edge of palette visibility.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  typedef enum logic [1:0] {
    PM_IDX8   = 2'b00,
    PM_MAP24  = 2'b01,
    PM_DIRALT = 2'b10,
    PM_DIR24  = 2'b11
  } pmode_e;

  // Modes with the high bit clear go through the palette.
  function automatic logic mode_uses_pal(input logic [1:0] m);
    return !m[1];
  endfunction

  function automatic logic mode_is_index(input logic [1:0] m);
    return m == PM_IDX8;
  endfunction
endpackage

// File: rtl/pxm_palette.sv
module pxm_palette #(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CH_W-1:0]     waddr,
  input  logic [NCH*CH_W-1:0] wdata,
  input  logic [NCH*CH_W-1:0] raddr,
  output logic [NCH*CH_W-1:0] rdata
);
  localparam int DEPTH = 1 << CH_W;

  // One table per channel, each with its own read address.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
        mem[waddr] <= wdata[c*CH_W +: CH_W];
      end
    end

    assign rdata[c*CH_W +: CH_W] = mem[raddr[c*CH_W +: CH_W]];
  end
endmodule

// File: rtl/pxm_addr_sel.sv
module pxm_addr_sel #(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic [1:0]          mode,
  input  logic [NCH*CH_W-1:0] col,
  output logic [NCH*CH_W-1:0] raddr
);
  // Indexed mode: every channel reads at the low colour byte.
  // Otherwise each channel reads at its own colour byte.
  for (genvar c = 0; c < NCH; c++) begin : g_a
    assign raddr[c*CH_W +: CH_W] = pxm_pkg::mode_is_index(mode)
                                   ? col[CH_W-1:0]
                                   : col[c*CH_W +: CH_W];
  end
endmodule

// File: rtl/pxmode_out.sv
module pxmode_out #(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_vld,
  input  logic [NCH*CH_W+1:0]   pix_word,
  input  logic                  pal_we,
  input  logic [CH_W-1:0]       pal_addr,
  input  logic [NCH*CH_W-1:0]   pal_data,
  output logic                  rgb_vld,
  output logic [NCH*CH_W-1:0]   rgb
);
  localparam int COL_W = NCH * CH_W;

  function automatic logic [COL_W-1:0] colour_of(input logic [COL_W+1:0] w);
    return w[COL_W-1:0];
  endfunction

  function automatic logic [1:0] mode_of(input logic [COL_W+1:0] w);
    return w[COL_W +: 2];
  endfunction

  // Stage 1: registered pixel
  logic             s1_vld;
  logic [1:0]       s1_mode;
  logic [COL_W-1:0] s1_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_mode <= '0;
      s1_col  <= '0;
    end else begin
      s1_vld <= pix_vld;
      if (pix_vld) begin
        s1_mode <= mode_of(pix_word);
        s1_col  <= colour_of(pix_word);
      end
    end
  end

  // Named internal events for the checker
  logic             s1_bypass;
  logic [COL_W-1:0] rd_addr;
  logic [COL_W-1:0] pal_rd;
  logic [COL_W-1:0] s2_next;

  assign s1_bypass = !pxm_pkg::mode_uses_pal(s1_mode);

  pxm_addr_sel #(.CH_W(CH_W), .NCH(NCH)) u_asel (
    .mode  (s1_mode),
    .col   (s1_col),
    .raddr (rd_addr)
  );

  pxm_palette #(.CH_W(CH_W), .NCH(NCH)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_data),
    .raddr (rd_addr),
    .rdata (pal_rd)
  );

  assign s2_next = s1_bypass ? s1_col : pal_rd;

  // Stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_vld <= 1'b0;
      rgb     <= '0;
    end else begin
      rgb_vld <= s1_vld;
      if (s1_vld) rgb <= s2_next;
    end
  end
endmodule

// File: rtl/pxm_chk.sv
module pxm_chk #(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_vld,
  input logic                  s1_vld,
  input logic [1:0]            s1_mode,
  input logic                  s1_bypass,
  input logic [NCH*CH_W-1:0]   s1_col,
  input logic [NCH*CH_W-1:0]   rd_addr,
  input logic [NCH*CH_W-1:0]   pal_rd,
  input logic                  rgb_vld,
  input logic [NCH*CH_W-1:0]   rgb
);
  logic warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  p_stage1_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> s1_vld == $past(pix_vld));

  p_out_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> rgb_vld == $past(s1_vld));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(rgb));

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_bypass) |=> rgb == $past(s1_col));

  p_mapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_bypass) |=> rgb == $past(pal_rd));

  p_chan_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mode == 2'b01) |-> rd_addr == s1_col);

  p_idx_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mode == 2'b00) |-> rd_addr == {NCH{s1_col[CH_W-1:0]}});
endmodule

bind pxmode_out pxm_chk #(.CH_W(CH_W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_vld   (pix_vld),
  .s1_vld    (s1_vld),
  .s1_mode   (s1_mode),
  .s1_bypass (s1_bypass),
  .s1_col    (s1_col),
  .rd_addr   (rd_addr),
  .pal_rd    (pal_rd),
  .rgb_vld   (rgb_vld),
  .rgb       (rgb)
);

// File: tb/pxmode_out_tb.sv
module pxmode_out_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_vld = 1'b0;
  logic [25:0] pix_word = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_data = '0;
  logic        rgb_vld;
  logic [23:0] rgb;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { logic [23:0] exp; int due; string tag; } item_t;
  item_t q[$];
  logic [23:0] mdl [256];
  logic [23:0] last_rgb = '0;

  always #10 clk = ~clk;                 // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pxmode_out u_dut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_word(pix_word),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
    .rgb_vld(rgb_vld), .rgb(rgb)
  );

  // Reference model written from the requirements.
  function automatic logic [23:0] model(input logic [1:0] m, input logic [23:0] c);
    case (m)
      2'b00:   return mdl[c[7:0]];                              // R2
      2'b01:   return {mdl[c[23:16]][23:16], mdl[c[15:8]][15:8],
                       mdl[c[7:0]][7:0]};                       // R5
      default: return c;                                        // R3 and R4
    endcase
  endfunction

  function automatic logic [23:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h3C, ~b, b + 8'h11};
  endfunction

  // Driver: called at a negative edge; drives one cycle, then waits.
  task automatic step(input bit v, input logic [1:0] m, input logic [23:0] c,
                      input bit we, input logic [7:0] wa, input logic [23:0] wd,
                      input string tag);
    item_t it;
    pix_vld  = v;
    pix_word = {m, c};
    pal_we   = we;
    pal_addr = wa;
    pal_data = wd;
    if (we) mdl[wa] = wd;   // R7: a write in the pixel's own cycle is visible
    if (v) begin
      it.exp = model(m, c);
      it.due = cyc + 2;
      it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    pix_vld = 1'b0;
    pal_we  = 1'b0;
  endtask

  task automatic pix(input logic [1:0] m, input logic [23:0] c, input string tag);
    step(1'b1, m, c, 1'b0, 8'h00, 24'h0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 24'h0, 1'b0, 8'h00, 24'h0, "");
  endtask

  task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                     input logic [23:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rgb_vld) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6 unexpected valid", rgb, 24'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(it.due == cyc, {it.tag, " latency"}, 24'(cyc), 24'(it.due));
          chk(rgb === it.exp, it.tag, rgb, it.exp);
        end
        last_rgb = rgb;
      end else begin
        if (q.size() != 0 && q[0].due <= cyc)
          chk(1'b0, "R6 missing valid", 24'(cyc), 24'(q[0].due));
        if (rgb !== last_rgb) chk(1'b0, "R6 hold", rgb, last_rgb);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(rgb_vld === 1'b0, "R9 valid in reset", 24'(rgb_vld), 24'h0);
    chk(rgb === 24'h0, "R9 rgb in reset", rgb, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rgb_vld === 1'b0 && rgb === 24'h0, "R9 after reset", rgb, 24'h0);

    // R9: palette is zero after reset
    pix(2'b00, 24'hFFFF55, "R9 zero palette idx");
    pix(2'b01, 24'h123456, "R9 zero palette map");
    idle(3);

    // R7: load the full table with distinct patterns
    for (int i = 0; i < 256; i++) step(1'b0, 2'b00, 24'h0, 1'b1, 8'(i), pat(i), "");
    idle(2);

    // R2: indexed lookups, upper colour bytes ignored (R1)
    pix(2'b00, 24'h000000, "R2 idx 0");
    pix(2'b00, 24'hABCDFF, "R2 idx FF upper ignored");
    pix(2'b00, 24'h77007E, "R2 idx 7E");
    // R5: per-channel mapping
    pix(2'b01, 24'h01FE80, "R5 map");
    pix(2'b01, 24'hFF0000, "R5 map ends");
    pix(2'b01, 24'h3C3C3C, "R5 map same bytes");
    // R3 and R4: direct, mode bits absent from output (R1)
    pix(2'b11, 24'hDEADBE, "R3 direct");
    pix(2'b11, 24'hFFFFFF, "R3 direct all ones");
    pix(2'b10, 24'h0F1E2D, "R4 mode 10 direct");
    idle(1);
    // R6: mixed modes back to back with gaps
    pix(2'b00, 24'h000012, "R6 mix idx");
    pix(2'b11, 24'h102030, "R6 mix direct");
    idle(2);
    pix(2'b01, 24'h405060, "R6 mix map");
    pix(2'b10, 24'h000001, "R6 mix alt");
    idle(4);

    // R7: write in the same cycle as the pixel is seen
    step(1'b1, 2'b00, 24'h000040, 1'b1, 8'h40, 24'hA1B2C3, "R7 same-cycle write");
    idle(2);
    // R8: write one cycle after the pixel is not seen
    pix(2'b00, 24'h000041, "R8 old entry");
    step(1'b0, 2'b00, 24'h0, 1'b1, 8'h41, 24'h5A5A5A, "");
    pix(2'b00, 24'h000041, "R7 new entry visible");
    pix(2'b01, 24'h414141, "R5 map after update");
    idle(5);

    chk(q.size() == 0, "R6 all results delivered", 24'(q.size()), 24'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule